// File: doc/BRIEF.md
# Snooping cache line coherence controller

This block tracks the coherence state of each line held by one private cache and decides how that cache talks to a shared snoop bus. It takes one local request per cycle: read, write, evict or clean. For each request it returns the line's next state, any bus request to issue, and whether memory must be written. It also takes one snooped request per cycle from another cache: read, read-for-ownership or invalidate. For a snoop it returns whether this cache holds the line, whether it must supply the data to the requester, and whether it must write back.

A parameter selects one of two extended policies. In owner mode a dirty line that is read remotely becomes the owner. The owner keeps supplying data cache-to-cache and keeps the duty to write back later. In forwarder mode one clean copy acts as the single designated responder. That role always moves to the newest reader.

The shared-response input tells a requester whether any other cache holds the line. The surrounding system forms it by ORing the hit outputs of the other controllers. Data storage, tag matching, bus arbitration and memory are outside the block.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. State codes are Invalid=0, Shared=1, Exclusive=2, Modified=3, Owner=4, Forwarder=5, and `line_state` shows the state of line `loc_idx` whenever `loc_valid` is low.
- R2: A local read (loc_op=0) to an Invalid line issues a bus read (bus_op=0). The line installs as Exclusive when `shared_in` is low. When `shared_in` is high it installs as Forwarder in forwarder mode and as Shared in owner mode. A read to a valid line issues nothing and keeps its state.
- R3: A local write (loc_op=1) leaves the line Modified. From Invalid it issues read-for-ownership (bus_op=1). From Shared, Owner or Forwarder it issues invalidate (bus_op=2). From Exclusive or Modified it issues nothing.
- R4: A local evict (loc_op=2) makes the line Invalid. It asserts `wb_req` only when the line was Modified or Owner.
- R5: A local clean (loc_op=3) writes back a Modified line, which becomes Exclusive, and an Owner line, which becomes Shared. Any other state is kept without a writeback.
- R6: A snooped read (snp_op=0) that hits a Modified line supplies the data. In owner mode the line becomes Owner with no writeback. In forwarder mode the line writes back and becomes Shared.
- R7: A snooped read of an Owner line supplies the data and the line stays Owner. A Forwarder line supplies and becomes Shared. An Exclusive line becomes Shared and supplies only in forwarder mode. A Shared line stays Shared without supplying. `snp_hit` is high whenever a snooped line is not Invalid.
- R8: A snooped read-for-ownership (snp_op=1) or invalidate (snp_op=2) makes the line Invalid with no writeback. Read-for-ownership supplies data from Modified, Owner or Forwarder, and from Exclusive in forwarder mode. Invalidate supplies nothing.
- R9: When a snoop and a local request address the same line in one cycle, the snoop is applied and the local request is ignored: no bus request, no local writeback, and `line_state` shows the unchanged current state.
- R10: Across caches on one bus, each line has at most one Forwarder and at most one Owner. A Modified or Exclusive copy is the only valid copy. Owner never appears in forwarder mode and Forwarder never appears in owner mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local request present |
| loc_op | input | 2 | Local request: 0 read, 1 write, 2 evict, 3 clean |
| loc_idx | input | IW | Line addressed by the local request |
| shared_in | input | 1 | Another cache holds the line of this cache's bus request |
| snp_valid | input | 1 | Snooped request present |
| snp_op | input | 2 | Snooped request: 0 read, 1 read-for-ownership, 2 invalidate |
| snp_idx | input | IW | Line addressed by the snoop |
| line_state | output | 3 | Next state of line `loc_idx` |
| bus_valid | output | 1 | Bus request to issue |
| bus_op | output | 2 | Bus request: 0 read, 1 read-for-ownership, 2 invalidate |
| wb_req | output | 1 | Write the line's data back to memory |
| supply_req | output | 1 | Supply this line's data to the snooping requester |
| snp_hit | output | 1 | Snooped line is held (drives the requester's shared response) |

## Verification
On every cycle, the assertions check the following:
- A local write always ends in Modified.
- An evict always ends in Invalid.
- A clean read miss becomes Exclusive.
- A read-for-ownership or invalidate snoop always ends in Invalid.
- Supply is never raised without a snoop.
- Each line is kept out of the state that the chosen policy forbids.

The bench's scenarios are the only place where the cross-cache behaviour shows. It runs three controllers of each policy on one snoop bus. There it checks that exactly one responder supplies data. It checks that the forwarder role moves to the newest reader. It checks that an owner keeps the writeback duty until it is evicted or cleaned. It also checks the per-line invariants across all caches and the ignored local request on a same-line collision.

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl #(
  parameter bit FWD_MODE = 1'b0,
  parameter int LINES = 8,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loc_valid,
  input  logic [1:0]    loc_op,
  input  logic [IW-1:0] loc_idx,
  input  logic          shared_in,
  input  logic          snp_valid,
  input  logic [1:0]    snp_op,
  input  logic [IW-1:0] snp_idx,
  output logic [2:0]    line_state,
  output logic          bus_valid,
  output logic [1:0]    bus_op,
  output logic          wb_req,
  output logic          supply_req,
  output logic          snp_hit
);
  localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2,
                         ST_M = 3'd3, ST_O = 3'd4, ST_F = 3'd5;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2, OP_CL = 2'd3;
  localparam logic [1:0] BUS_RD = 2'd0, BUS_RFO = 2'd1, BUS_INV = 2'd2;
  localparam logic [2:0] ST_BAD = FWD_MODE ? ST_O : ST_F;

  logic [2:0] st [LINES];
  logic [2:0] l_cur, l_next, s_cur, s_next;
  logic       l_wb, s_wb, loc_go;

  assign loc_go = loc_valid && !(snp_valid && snp_idx == loc_idx);
  assign l_cur  = st[loc_idx];
  assign s_cur  = st[snp_idx];
  assign line_state = l_next;
  assign snp_hit = snp_valid && (s_cur != ST_I);
  assign wb_req  = l_wb || s_wb;

  always_comb begin
    l_next    = l_cur;
    bus_valid = 1'b0;
    bus_op    = BUS_RD;
    l_wb      = 1'b0;
    if (loc_go) begin
      case (loc_op)
        OP_RD: if (l_cur == ST_I) begin
          bus_valid = 1'b1;
          l_next = !shared_in ? ST_E : (FWD_MODE ? ST_F : ST_S);
        end
        OP_WR: begin
          l_next = ST_M;
          if (l_cur == ST_I) begin
            bus_valid = 1'b1;
            bus_op = BUS_RFO;
          end else if (l_cur != ST_E && l_cur != ST_M) begin
            bus_valid = 1'b1;
            bus_op = BUS_INV;
          end
        end
        OP_EV: begin
          l_wb = (l_cur == ST_M) || (l_cur == ST_O);
          l_next = ST_I;
        end
        default: if (l_cur == ST_M) begin
          l_wb = 1'b1;
          l_next = ST_E;
        end else if (l_cur == ST_O) begin
          l_wb = 1'b1;
          l_next = ST_S;
        end
      endcase
    end
  end

  always_comb begin
    s_next     = s_cur;
    supply_req = 1'b0;
    s_wb       = 1'b0;
    if (snp_valid) begin
      if (snp_op == BUS_RD) begin
        case (s_cur)
          ST_M: begin
            supply_req = 1'b1;
            s_wb = FWD_MODE;
            s_next = FWD_MODE ? ST_S : ST_O;
          end
          ST_E: begin
            supply_req = FWD_MODE;
            s_next = ST_S;
          end
          ST_O: supply_req = 1'b1;
          ST_F: begin
            supply_req = 1'b1;
            s_next = ST_S;
          end
          default: s_next = s_cur;
        endcase
      end else begin
        s_next = ST_I;
        supply_req = (snp_op == BUS_RFO) &&
                     (s_cur == ST_M || s_cur == ST_O || s_cur == ST_F ||
                      (FWD_MODE && s_cur == ST_E));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st[i] <= ST_I;
    end else begin
      if (snp_valid) st[snp_idx] <= s_next;
      if (loc_go) st[loc_idx] <= l_next;
    end
  end

  a_r2_clean_miss_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_go && loc_op == OP_RD && l_cur == ST_I && !shared_in) |=> st[$past(loc_idx)] == ST_E);
  a_r3_write_ends_modified: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_go && loc_op == OP_WR) |=> st[$past(loc_idx)] == ST_M);
  a_r4_evict_ends_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_go && loc_op == OP_EV) |=> st[$past(loc_idx)] == ST_I);
  a_r8_snoop_kill_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op != BUS_RD) |=> st[$past(snp_idx)] == ST_I);
  a_r7_supply_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    supply_req |-> snp_hit);
  a_r9_collision_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && snp_valid && loc_idx == snp_idx) |-> !bus_valid);

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    a_r10_policy_state: assert property (@(posedge clk) disable iff (!rst_n)
      st[i] != ST_BAD);
  end
endmodule

// File: tb/test_coh_line_ctrl.sv
module test_coh_line_ctrl;
  localparam int CLK_NS = 10;
  localparam int NC = 3;
  localparam int NL = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic lv [NC];
  logic [1:0] lop [NC];
  logic [IW-1:0] lidx [NC];
  int rq = 0;
  logic sv [2][NC];
  logic [1:0] sop [2][NC];
  logic [IW-1:0] sidx [2][NC];
  logic sh [2][NC];
  logic [2:0] ls [2][NC];
  logic bv [2][NC], wb [2][NC], sup [2][NC], hit [2][NC];
  logic [1:0] bo [2][NC];

  for (genvar gp = 0; gp < 2; gp++) begin : g_pol
    for (genvar gk = 0; gk < NC; gk++) begin : g_c
      coh_line_ctrl #(.FWD_MODE(gp == 1), .LINES(NL)) i_coh_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .loc_valid(lv[gk]), .loc_op(lop[gk]), .loc_idx(lidx[gk]),
        .shared_in(sh[gp][gk]),
        .snp_valid(sv[gp][gk]), .snp_op(sop[gp][gk]), .snp_idx(sidx[gp][gk]),
        .line_state(ls[gp][gk]), .bus_valid(bv[gp][gk]), .bus_op(bo[gp][gk]),
        .wb_req(wb[gp][gk]), .supply_req(sup[gp][gk]), .snp_hit(hit[gp][gk]));
    end
  end

  always_comb
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < NC; k++) begin
        sv[p][k] = (k != rq) && bv[p][rq];
        sop[p][k] = bo[p][rq];
        sidx[p][k] = lidx[rq];
      end

  always_comb
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < NC; k++) begin
        sh[p][k] = 1'b0;
        if (k == rq)
          for (int j = 0; j < NC; j++)
            if (j != k && hit[p][j]) sh[p][k] = 1'b1;
      end

  int m [2][NC][NL];
  int checks = 0, fails = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // returns {bus_valid, bus_op[1:0], wb, next[2:0]}
  function automatic logic [6:0] exp_loc(bit fwd, int cur, int op, bit shd);
    logic bvx = 0; logic [1:0] box = 0; logic wbx = 0; logic [2:0] nx = cur[2:0];
    case (op)
      0: if (cur == 0) begin bvx = 1; nx = !shd ? 3'd2 : (fwd ? 3'd5 : 3'd1); end
      1: begin
        nx = 3'd3;
        if (cur == 0) begin bvx = 1; box = 2'd1; end
        else if (cur != 2 && cur != 3) begin bvx = 1; box = 2'd2; end
      end
      2: begin wbx = (cur == 3 || cur == 4); nx = 3'd0; end
      default: if (cur == 3) begin wbx = 1; nx = 3'd2; end
               else if (cur == 4) begin wbx = 1; nx = 3'd1; end
    endcase
    return {bvx, box, wbx, nx};
  endfunction

  // returns {supply, wb, next[2:0]}
  function automatic logic [4:0] exp_snp(bit fwd, int cur, int sop_i);
    logic s = 0; logic w = 0; logic [2:0] nx = cur[2:0];
    if (sop_i == 0) begin
      case (cur)
        3: begin s = 1; w = fwd; nx = fwd ? 3'd1 : 3'd4; end
        2: begin s = fwd; nx = 3'd1; end
        4: s = 1;
        5: begin s = 1; nx = 3'd1; end
        default: ;
      endcase
    end else begin
      nx = 3'd0;
      s = (sop_i == 1) && (cur == 3 || cur == 4 || cur == 5 || (fwd && cur == 2));
    end
    return {s, w, nx};
  endfunction

  task automatic do_cycle(int r, int op, int idx, int xc, int xop);
    int nx [2][NC];
    logic [6:0] el;
    logic [4:0] es;
    string tag, stag;
    bit shd;
    int ew [NC];
    @(negedge clk);
    for (int k = 0; k < NC; k++) lv[k] = 0;
    rq = r; lv[r] = 1; lop[r] = op[1:0]; lidx[r] = idx[IW-1:0];
    if (xc >= 0) begin lv[xc] = 1; lop[xc] = xop[1:0]; lidx[xc] = idx[IW-1:0]; end
    #1;
    tag = (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R5";
    for (int p = 0; p < 2; p++) begin
      shd = 0;
      for (int k = 0; k < NC; k++)
        if (k != r && m[p][k][idx] != 0) shd = 1;
      el = exp_loc(p == 1, m[p][r][idx], op, shd);
      for (int k = 0; k < NC; k++) begin ew[k] = 0; nx[p][k] = m[p][k][idx]; end
      chk(ls[p][r] == el[2:0], tag, "line_state", ls[p][r], el[2:0]);
      chk(bv[p][r] == el[6], tag, "bus_valid", bv[p][r], el[6]);
      if (el[6]) chk(bo[p][r] == el[5:4], tag, "bus_op", bo[p][r], el[5:4]);
      ew[r] = el[3]; nx[p][r] = el[2:0];
      stag = (el[6] && el[5:4] == 0) ? ((m[p][0][idx] == 3 || m[p][1][idx] == 3 ||
              m[p][2][idx] == 3) ? "R6" : "R7") : "R8";
      for (int k = 0; k < NC; k++) if (k != r) begin
        if (el[6]) begin
          es = exp_snp(p == 1, m[p][k][idx], el[5:4]);
          chk(sup[p][k] == es[4], stag, "supply_req", sup[p][k], es[4]);
          chk(hit[p][k] == (m[p][k][idx] != 0), "R7", "snp_hit", hit[p][k], m[p][k][idx] != 0);
          ew[k] = es[3]; nx[p][k] = es[2:0];
        end else
          chk(sup[p][k] == 0, stag, "supply_req idle", sup[p][k], 0);
      end
      if (xc >= 0)
        chk(ls[p][xc] == m[p][xc][idx], "R9", "ignored local line_state", ls[p][xc], m[p][xc][idx]);
      for (int k = 0; k < NC; k++)
        chk(wb[p][k] == ew[k][0], (k == r) ? tag : (xc == k ? "R9" : stag), "wb_req", wb[p][k], ew[k]);
    end
    @(posedge clk);
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < NC; k++) m[p][k][idx] = nx[p][k];
  endtask

  task automatic peek(string tag);
    int nf, no, nme, nvld;
    @(negedge clk);
    for (int k = 0; k < NC; k++) lv[k] = 0;
    for (int i = 0; i < NL; i++) begin
      for (int k = 0; k < NC; k++) lidx[k] = i[IW-1:0];
      #1;
      for (int p = 0; p < 2; p++) begin
        nf = 0; no = 0; nme = 0; nvld = 0;
        for (int k = 0; k < NC; k++) begin
          chk(ls[p][k] == m[p][k][i], tag, "peek state", ls[p][k], m[p][k][i]);
          if (ls[p][k] == 5) nf++;
          if (ls[p][k] == 4) no++;
          if (ls[p][k] == 2 || ls[p][k] == 3) nme++;
          if (ls[p][k] != 0) nvld++;
          chk(ls[p][k] != ((p == 1) ? 4 : 5), "R10", "policy state", ls[p][k], 0);
        end
        chk(nf <= 1 && no <= 1 && (nme == 0 || nvld == 1), "R10", "line invariant", nvld, nme);
      end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NC; k++) begin lv[k] = 0; lop[k] = 0; lidx[k] = 0; end
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < NC; k++)
        for (int i = 0; i < NL; i++) m[p][k][i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    peek("R1");
    do_cycle(0, 0, 0, -1, 0);   // R2 clean miss -> E
    do_cycle(1, 0, 0, -1, 0);   // R7 E snooped
    do_cycle(2, 0, 0, -1, 0);   // R7 responder migrates
    do_cycle(0, 1, 0, -1, 0);   // R3 upgrade with invalidate
    do_cycle(1, 0, 0, -1, 0);   // R6 M snooped by read
    do_cycle(2, 0, 0, -1, 0);   // R7 owner supplies again
    do_cycle(0, 3, 0, -1, 0);   // R5 clean
    do_cycle(1, 1, 1, -1, 0);   // R3 write miss
    do_cycle(1, 3, 1, -1, 0);   // R5 M clean -> E
    do_cycle(1, 1, 1, -1, 0);   // R3 silent E -> M
    do_cycle(2, 1, 1, -1, 0);   // R8 RFO on M
    do_cycle(2, 2, 1, -1, 0);   // R4 evict M
    peek("R10");
    do_cycle(0, 1, 2, -1, 0);
    do_cycle(1, 1, 2, 0, 2);    // R9 collision: evict of M ignored
    peek("R9");
    void'($urandom(32'd4242));
    for (int n = 0; n < 2500; n++) begin
      do_cycle(int'($urandom % NC), int'($urandom % 4), int'($urandom % NL), -1, 0);
      if (n % 25 == 24) peek("R10");
    end
    peek("R10");
    finish_run();
  end
endmodule